// File: doc/BRIEF.md
# Cross-Domain Control Register Bridge

This block keeps one 32-bit control word that is written from a bus clock domain and used in a separate core clock domain. The word carries a stop level, two self-clearing requests and a 16-bit divider. Each field crosses into the core domain through synchronizers. Reads return the core-domain copy, brought back through a second set of synchronizers. Software can therefore poll the readback to learn when a change has taken effect.

In the core domain the block emits a periodic sampling enable whose period comes from the divider. For each accepted clear request it emits exactly one single-cycle pulse. The two request bits are handled by toggle handshakes. Each one reads as 1 from the write until the core domain has observed it, and then drops without any reset being applied.

Top module: `xdom_ctrl_bridge`

## Requirements
- R1: After reset in both domains the readback is 0x00000001 (stopped, divider 0, no requests pending), `core_disable` is 1 and no sampling enable or clear pulse is produced.
- R2: Field layout: bit 0 is the stop bit, bit 1 is the clock-error clear request, bit 2 is the health-error clear request, and bits 31:16 are the divider. Bits 15:3 always read 0, whatever was written to them.
- R3: Readback bit 0 shows the core-domain stop value synchronized back. In the bus cycle after a write that changes it, the readback still holds the old value. It then matches the written value within 40 bus cycles.
- R4: `core_disable` follows the written stop bit. While it has been 1 for more than one core cycle, `core_sample_en` is 0.
- R5: With the core running, `core_sample_en` is high for one core cycle in every N+1 core cycles, where N is the divider value. N = 0 gives an enable on every cycle. The count restarts whenever the divider changes.
- R6: Writing 1 to a clear-request bit makes that bit read 1 until the core domain has taken the request. After that it reads 0 by itself. The core domain emits exactly one pulse, one core cycle wide, on the matching output.
- R7: Writing 0 to a clear-request bit has no effect. A write of 1 while the same request is still pending is merged into it and produces no extra pulse.
- R8: A clear request leaves the stop bit and the divider unchanged. The two request channels are independent: each one pulses only its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus domain clock |
| bus_rst | input | 1 | Bus domain synchronous reset, active high |
| bus_wr_en | input | 1 | Write strobe for the control word |
| bus_wr_data | input | 32 | Control word to be written |
| bus_rd_data | output | 32 | Readback of the core-domain copy and the pending requests |
| core_clk | input | 1 | Core domain clock |
| core_rst | input | 1 | Core domain synchronous reset, active high |
| core_disable | output | 1 | Core-domain stop level |
| core_sample_en | output | 1 | Periodic sampling enable |
| core_clr_clkerr | output | 1 | One-cycle clock-error clear pulse |
| core_clr_health | output | 1 | One-cycle health-error clear pulse |

## Verification
If a handshake toggle is lost or duplicated, the effect shows within a few cycles of either clock. The request bit either never drops, so the poll times out, or the pulse count differs from the number of accepted writes. A corrupted divider or counter shows on the first enable interval that is measured, because every interval is compared with N+1 core cycles. A stuck synchronizer shows as a readback that never matches what was written, or that changes earlier than the crossing delay allows.

// File: rtl/xcb_pkg.sv
package xcb_pkg;
    localparam int REG_W       = 32;
    localparam int DIV_W       = 16;
    localparam int DIV_LSB     = 16;
    localparam int STOP_BIT    = 0;
    localparam int NUM_CLR     = 2;
    localparam int CLR_BIT0    = 1;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic             stop;
        logic [DIV_W-1:0] div;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
    localparam logic [CFG_W-1:0] CFG_RST = {1'b1, {DIV_W{1'b0}}};

    function automatic cfg_t word_to_cfg(input logic [REG_W-1:0] w);
        cfg_t c;
        c.stop = w[STOP_BIT];
        c.div  = w[DIV_LSB +: DIV_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] build_readback(input cfg_t c,
                                                        input logic [NUM_CLR-1:0] pend);
        logic [REG_W-1:0] r;
        r = '0;
        r[STOP_BIT]              = c.stop;
        r[CLR_BIT0 +: NUM_CLR]   = pend;
        r[DIV_LSB +: DIV_W]      = c.div;
        return r;
    endfunction
endpackage

// File: rtl/xcb_sync.sv
module xcb_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xcb_clr_chan.sv
module xcb_clr_chan #(
    parameter int STAGES = 2
) (
    input  logic bus_clk,
    input  logic bus_rst,
    input  logic set_req,
    output logic pending,
    input  logic core_clk,
    input  logic core_rst,
    output logic core_pulse
);
    logic req_tgl_q;
    logic ack_tgl_s;
    logic req_tgl_s;
    logic seen_q;

    // bus side: flip the request toggle only when nothing is in flight
    assign pending = req_tgl_q ^ ack_tgl_s;

    always_ff @(posedge bus_clk) begin
        if (bus_rst) req_tgl_q <= 1'b0;
        else if (set_req && !pending) req_tgl_q <= ~req_tgl_q;
    end

    xcb_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) req_sync_i (
        .clk(core_clk), .rst(core_rst), .d(req_tgl_q), .q(req_tgl_s)
    );

    // core side: a change of the synced toggle is one request
    always_ff @(posedge core_clk) begin
        if (core_rst) seen_q <= 1'b0;
        else          seen_q <= req_tgl_s;
    end

    assign core_pulse = req_tgl_s ^ seen_q;

    xcb_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) ack_sync_i (
        .clk(bus_clk), .rst(bus_rst), .d(seen_q), .q(ack_tgl_s)
    );
endmodule

// File: rtl/xcb_samp_gen.sv
module xcb_samp_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop,
    input  logic [DIV_W-1:0] div,
    output logic             en
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_prev_q;
    logic             div_moved;

    assign div_moved = (div != div_prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            div_prev_q <= '0;
            en         <= 1'b0;
        end else begin
            div_prev_q <= div;
            if (stop || div_moved) begin
                cnt_q <= '0;
                en    <= 1'b0;
            end else if (cnt_q == div) begin
                cnt_q <= '0;
                en    <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                en    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/xdom_ctrl_bridge.sv
module xdom_ctrl_bridge
    import xcb_pkg::*;
(
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             bus_wr_en,
    input  logic [REG_W-1:0] bus_wr_data,
    output logic [REG_W-1:0] bus_rd_data,
    input  logic             core_clk,
    input  logic             core_rst,
    output logic             core_disable,
    output logic             core_sample_en,
    output logic             core_clr_clkerr,
    output logic             core_clr_health
);
    cfg_t               bus_cfg_q;
    cfg_t               core_cfg;
    cfg_t               back_cfg;
    logic [NUM_CLR-1:0] pend;
    logic [NUM_CLR-1:0] pulses;

    always_ff @(posedge bus_clk) begin
        if (bus_rst)        bus_cfg_q <= cfg_t'(CFG_RST);
        else if (bus_wr_en) bus_cfg_q <= word_to_cfg(bus_wr_data);
    end

    xcb_sync #(.W(CFG_W), .STAGES(SYNC_STAGES), .RST_VAL(CFG_RST)) fwd_sync_i (
        .clk(core_clk), .rst(core_rst), .d(bus_cfg_q), .q(core_cfg)
    );

    xcb_sync #(.W(CFG_W), .STAGES(SYNC_STAGES), .RST_VAL(CFG_RST)) back_sync_i (
        .clk(bus_clk), .rst(bus_rst), .d(core_cfg), .q(back_cfg)
    );

    for (genvar g = 0; g < NUM_CLR; g++) begin : g_clr
        xcb_clr_chan #(.STAGES(SYNC_STAGES)) chan_i (
            .bus_clk   (bus_clk),
            .bus_rst   (bus_rst),
            .set_req   (bus_wr_en && bus_wr_data[CLR_BIT0 + g]),
            .pending   (pend[g]),
            .core_clk  (core_clk),
            .core_rst  (core_rst),
            .core_pulse(pulses[g])
        );
    end

    xcb_samp_gen #(.DIV_W(DIV_W)) samp_i (
        .clk (core_clk),
        .rst (core_rst),
        .stop(core_cfg.stop),
        .div (core_cfg.div),
        .en  (core_sample_en)
    );

    assign core_disable    = core_cfg.stop;
    assign core_clr_clkerr = pulses[0];
    assign core_clr_health = pulses[1];
    assign bus_rd_data     = build_readback(back_cfg, pend);
endmodule

// File: rtl/xcb_bridge_chk.sv
module xcb_bridge_chk (
    input logic        bus_clk,
    input logic        bus_rst,
    input logic        bus_wr_en,
    input logic [31:0] bus_wr_data,
    input logic [31:0] bus_rd_data,
    input logic        core_clk,
    input logic        core_rst,
    input logic        core_disable,
    input logic        core_sample_en,
    input logic        core_clr_clkerr,
    input logic        core_clr_health
);
    assert_rst_readback_R1: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $past(bus_rst) |-> (bus_rd_data == 32'h0000_0001));

    assert_stop_lag_R3: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (bus_wr_en && (bus_wr_data[0] != bus_rd_data[0])) |=> $stable(bus_rd_data[0]));

    assert_stopped_no_en_R4: assert property (@(posedge core_clk) disable iff (core_rst)
        (core_disable && $past(core_disable)) |-> !core_sample_en);

    assert_clkerr_one_cycle_R6: assert property (@(posedge core_clk) disable iff (core_rst)
        core_clr_clkerr |=> !core_clr_clkerr);

    assert_health_one_cycle_R6: assert property (@(posedge core_clk) disable iff (core_rst)
        core_clr_health |=> !core_clr_health);

    assert_pend_held_R6: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $rose(bus_rd_data[1]) |=> bus_rd_data[1]);
endmodule

bind xdom_ctrl_bridge xcb_bridge_chk chk_i (
    .bus_clk        (bus_clk),
    .bus_rst        (bus_rst),
    .bus_wr_en      (bus_wr_en),
    .bus_wr_data    (bus_wr_data),
    .bus_rd_data    (bus_rd_data),
    .core_clk       (core_clk),
    .core_rst       (core_rst),
    .core_disable   (core_disable),
    .core_sample_en (core_sample_en),
    .core_clr_clkerr(core_clr_clkerr),
    .core_clr_health(core_clr_health)
);

// File: tb/xdom_ctrl_bridge_tb_top.sv
module xdom_ctrl_bridge_tb_top;
    logic        bus_clk = 1'b0;
    logic        core_clk = 1'b0;
    logic        bus_rst = 1'b1;
    logic        core_rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic [31:0] bus_rd_data;
    logic        core_disable, core_sample_en, core_clr_clkerr, core_clr_health;

    int n_total = 0;
    int n_fail  = 0;
    int pc_clk  = 0;
    int pc_hl   = 0;
    int wide_pulses = 0;
    logic prev_clk = 1'b0;
    logic prev_hl  = 1'b0;

    always #5 bus_clk = ~bus_clk;
    always #7 core_clk = ~core_clk;

    xdom_ctrl_bridge dut_i (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_wr_en(bus_wr_en),
        .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
        .core_clk(core_clk), .core_rst(core_rst), .core_disable(core_disable),
        .core_sample_en(core_sample_en), .core_clr_clkerr(core_clr_clkerr),
        .core_clr_health(core_clr_health)
    );

    always @(negedge core_clk) begin
        if (core_clr_clkerr) pc_clk++;
        if (core_clr_health) pc_hl++;
        if ((core_clr_clkerr && prev_clk) || (core_clr_health && prev_hl)) wide_pulses++;
        prev_clk = core_clr_clkerr;
        prev_hl  = core_clr_health;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] data);
        @(negedge bus_clk);
        bus_wr_en   = 1'b1;
        bus_wr_data = data;
        @(negedge bus_clk);
        bus_wr_en   = 1'b0;
    endtask

    task automatic wait_rd(input logic [31:0] mask, input logic [31:0] exp, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if ((bus_rd_data & mask) == exp) begin
                ok = 1'b1;
                break;
            end
            @(negedge bus_clk);
        end
    endtask

    task automatic wait_en(output int c);
        c = 0;
        do begin
            @(negedge core_clk);
            c++;
        end while (!core_sample_en && c < 70000);
    endtask

    task automatic measure_period(input int d);
        int c;
        wait_en(c);
        for (int k = 0; k < 3; k++) begin
            wait_en(c);
            check(c == d + 1, $sformatf("R5 period div=%0d", d), c, d + 1);
        end
    endtask

    initial begin
        #1_500_000;
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        bit ok;
        int base_c, base_h, seen_en;
        logic [31:0] cur;

        repeat (10) @(negedge bus_clk);
        bus_rst  = 1'b0;
        core_rst = 1'b0;
        @(negedge bus_clk);
        // R1: reset state
        check(bus_rd_data == 32'h1, "R1 readback", bus_rd_data, 32'h1);
        check(core_disable == 1'b1, "R1 core_disable", core_disable, 1);
        seen_en = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge core_clk);
            if (core_sample_en || core_clr_clkerr || core_clr_health) seen_en++;
        end
        check(seen_en == 0, "R1 quiet outputs", seen_en, 0);

        // R3: stop readback lags, then matches
        cur = 32'h0005_0000;
        bus_write(cur);
        check(bus_rd_data[0] == 1'b1, "R3 readback lag", bus_rd_data[0], 1);
        wait_rd(32'hFFFF_FFFF, cur, ok);
        check(ok, "R3 readback match", bus_rd_data, cur);
        @(negedge core_clk);
        check(core_disable == 1'b0, "R4 core_disable follows", core_disable, 0);

        // R2: bits 15:3 read zero
        bus_write(32'h0007_FFF8);
        wait_rd(32'hFFFF_FFFF, 32'h0007_0000, ok);
        check(ok, "R2 unused bits zero", bus_rd_data, 32'h0007_0000);

        // R5: period sweep
        for (int d = 0; d <= 10; d++) begin
            bus_write(d << 16);
            wait_rd(32'hFFFF_FFFF, d << 16, ok);
            check(ok, "R5 divider readback", bus_rd_data, d << 16);
            measure_period(d);
        end
        bus_write(32'd1000 << 16);
        wait_rd(32'hFFFF_FFFF, 32'd1000 << 16, ok);
        measure_period(1000);

        // R4: stopped means no enable
        bus_write(32'h0003_0001);
        wait_rd(32'hFFFF_FFFF, 32'h0003_0001, ok);
        check(ok, "R4 stop readback", bus_rd_data, 32'h0003_0001);
        repeat (3) @(negedge core_clk);
        seen_en = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge core_clk);
            if (core_sample_en) seen_en++;
        end
        check(seen_en == 0, "R4 enable held low", seen_en, 0);
        check(core_disable == 1'b1, "R4 core_disable high", core_disable, 1);

        // R6 / R8: single clock-error clear
        cur = 32'h0004_0000;
        bus_write(cur);
        wait_rd(32'hFFFF_FFFF, cur, ok);
        base_c = pc_clk; base_h = pc_hl;
        bus_write(cur | 32'h2);
        check(bus_rd_data[1] == 1'b1, "R6 pending reads 1", bus_rd_data[1], 1);
        wait_rd(32'h2, 32'h0, ok);
        check(ok, "R6 auto clear", bus_rd_data[1], 0);
        repeat (6) @(negedge core_clk);
        check(pc_clk - base_c == 1, "R6 one pulse", pc_clk - base_c, 1);
        check(pc_hl - base_h == 0, "R8 other channel quiet", pc_hl - base_h, 0);
        @(negedge bus_clk);
        check(bus_rd_data == cur, "R8 fields kept", bus_rd_data, cur);

        // R7: back-to-back write while pending merges
        base_c = pc_clk;
        @(negedge bus_clk);
        bus_wr_en = 1'b1; bus_wr_data = cur | 32'h2;
        @(negedge bus_clk);
        @(negedge bus_clk);
        bus_wr_en = 1'b0;
        wait_rd(32'h2, 32'h0, ok);
        repeat (6) @(negedge core_clk);
        check(pc_clk - base_c == 1, "R7 merged write", pc_clk - base_c, 1);

        // R7: writing 0 does nothing
        base_c = pc_clk; base_h = pc_hl;
        bus_write(cur);
        @(negedge bus_clk);
        check(bus_rd_data[2:1] == 2'b00, "R7 zero write pending", bus_rd_data[2:1], 0);
        repeat (10) @(negedge core_clk);
        check((pc_clk - base_c) + (pc_hl - base_h) == 0, "R7 zero write pulses",
              (pc_clk - base_c) + (pc_hl - base_h), 0);

        // R8: both channels together, then health alone
        base_c = pc_clk; base_h = pc_hl;
        bus_write(cur | 32'h6);
        check(bus_rd_data[2:1] == 2'b11, "R8 both pending", bus_rd_data[2:1], 3);
        wait_rd(32'h6, 32'h0, ok);
        repeat (6) @(negedge core_clk);
        check(pc_clk - base_c == 1 && pc_hl - base_h == 1, "R8 both pulses",
              (pc_clk - base_c) * 16 + (pc_hl - base_h), 32'h11);
        base_c = pc_clk; base_h = pc_hl;
        bus_write(cur | 32'h4);
        wait_rd(32'h4, 32'h0, ok);
        check(ok, "R6 health auto clear", bus_rd_data[2], 0);
        repeat (6) @(negedge core_clk);
        check(pc_hl - base_h == 1 && pc_clk == base_c, "R8 health only",
              (pc_clk - base_c) * 16 + (pc_hl - base_h), 1);

        // R6: repeated completed requests give one pulse each
        for (int n = 1; n <= 5; n++) begin
            base_c = pc_clk;
            for (int k = 0; k < n; k++) begin
                bus_write(cur | 32'h2);
                wait_rd(32'h2, 32'h0, ok);
            end
            repeat (6) @(negedge core_clk);
            check(pc_clk - base_c == n, "R6 pulse count", pc_clk - base_c, n);
        end
        check(wide_pulses == 0, "R6 pulse width", wide_pulses, 0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule